// File: doc/BRIEF.md
# Flash Write-Status Polling Responder

This block sits inside the device side of a parallel flash and decides what a host read returns while an internal program or erase job is running. A one-cycle strobe marks the end of the last write-enable pulse of a command sequence. From that point, reads that hit the right address carry a status bit in the top data bit, and every other read passes array data through unchanged. During a program job the status bit is the inverse of the top bit of the datum being written. During an erase job the bit reads 0 while the erase runs and 1 while it is suspended.

Commands aimed only at protected storage do not hang the device. A program job whose address falls in a protected sector, and an erase job whose selected sectors are all protected, each end after a fixed time: about 1 µs and about 100 µs. Both times are derived from a clock-frequency parameter. The normal program and erase durations are parameters, so simulations can keep them short. A program job may also be started while an erase job is suspended, and the suspended erase resumes its state once that program job has ended.

Top module: `flash_poll_responder`

## Requirements
- R1: After reset, no job is pending. A read returns `arr_data` unchanged, with `rd_status` = 0.
- R2: A read presented with `rd_en` high at clock edge k gives `rd_valid` = 1 and its result on `rd_data`/`rd_status` after edge k. `rd_valid` is 0 after an edge where `rd_en` was low.
- R3: While a program job runs, a read whose address equals the program address returns `rd_status` = 1 and `rd_data[DATA_W-1]` = the inverse of `cmd_msb`. Bits `DATA_W-2:0` are taken from `arr_data`.
- R4: A program job loaded at edge E0 stays active through edge E(PROG_CYC) and no longer. Reads sampled at later edges return array data, which holds the true datum.
- R5: If the program address lies in a sector whose `prot_map` bit is 1, the job lasts max(1, CLK_HZ/1e6) edges instead of PROG_CYC. Reads then return array data.
- R6: While an unsuspended erase job runs, a read whose sector (the top SECT_W address bits) is being erased returns `rd_status` = 1 with the top data bit 0.
- R7: An erase job with at least one selected, unprotected sector lasts ERASE_CYC running edges and then falls back to array data.
- R8: While `erase_susp` is 1 during an erase job, reads of the erased sectors return a top bit of 1. The erase countdown holds, so completion is delayed by the number of suspended edges.
- R9: A program command accepted while an erase job is suspended follows R3 and R5 for its own address. Erased-sector reads keep returning 1 during it, and the suspended erase job is still pending when it ends.
- R10: An erase job whose selected sectors are all protected reports status 0 on those sectors for max(1, CLK_HZ/1e4) edges, then falls back to array data.
- R11: When only some of the selected sectors are protected, status is reported only for the unprotected ones. Reads of the protected selected sectors return array data.
- R12: A read that misses the address rule during a job returns array data, and it does not change when the job ends.
- R13: A command strobe is ignored when the block is busy, unless it is a program command during a suspended erase. An erase command with an empty sector selection is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_done | input | 1 | One-cycle strobe: final write pulse of a command has ended |
| cmd_is_erase | input | 1 | 1 = erase command, 0 = program command |
| cmd_addr | input | ADDR_W | Program address |
| cmd_msb | input | 1 | Top bit of the datum being programmed |
| erase_sel | input | 2**SECT_W | Sectors selected for erase, one bit per sector |
| prot_map | input | 2**SECT_W | Sector protection, one bit per sector |
| erase_susp | input | 1 | Erase-suspend level |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| arr_data | input | DATA_W | Array contents at `rd_addr` |
| rd_valid | output | 1 | Registered read result is valid |
| rd_data | output | DATA_W | Registered read data |
| rd_status | output | 1 | 1 when the top bit of `rd_data` carries status |

## Verification
The bench uses CLK_HZ = 10 MHz, which makes the protected-program window 10 cycles and the all-protected erase window 1000 cycles. It also sets PROG_CYC = 6 and ERASE_CYC = 40. With these values every job's last status edge and first array edge can be sampled directly, including an erase stretched by a 10-cycle suspension and the full 1000-cycle protected-erase timeout. ADDR_W = 8 and SECT_W = 2 give four 64-byte sectors, which is enough to mix selected, protected and untouched sectors in one command.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2,
    ST_SPROG = 2'd3
  } fpr_state_e;

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpr_timer.sv
module fpr_timer #(
  parameter int unsigned MAXV = 16,
  localparam int unsigned W = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         fin
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run && cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign fin = run && !load && (cnt == W'(1));

  // R8: a paused countdown keeps its value
  a_r8_hold_when_paused: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt));

  // R7: the finishing edge leaves the counter empty
  a_r7_fin_empties: assert property (@(posedge clk) disable iff (rst)
    fin |=> (cnt == '0));

endmodule

// File: rtl/fpr_ctrl.sv
module fpr_ctrl
  import fpr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned SECT_W    = 4,
  parameter int unsigned PW        = 8,
  parameter int unsigned EW        = 16,
  parameter int unsigned PROG_CYC  = 200,
  parameter int unsigned ERASE_CYC = 20000,
  parameter int unsigned PPROT_CYC = 50,
  parameter int unsigned EPROT_CYC = 5000,
  localparam int unsigned NSECT    = 2 ** SECT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_done,
  input  logic              cmd_is_erase,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_msb,
  input  logic [NSECT-1:0]  erase_sel,
  input  logic [NSECT-1:0]  prot_map,
  input  logic              erase_susp,
  input  logic              p_fin,
  input  logic              e_fin,
  output fpr_state_e        state,
  output logic              p_load,
  output logic [PW-1:0]     p_val,
  output logic              p_run,
  output logic              e_load,
  output logic [EW-1:0]     e_val,
  output logic              e_run,
  output logic [ADDR_W-1:0] pa,
  output logic              pd7,
  output logic [NSECT-1:0]  emask
);

  logic [SECT_W-1:0] psec;
  logic              pprot;
  logic [NSECT-1:0]  live;
  logic              start_prog;
  logic              start_erase;

  assign psec  = cmd_addr[ADDR_W-1 -: SECT_W];
  assign pprot = prot_map[psec];
  assign live  = erase_sel & ~prot_map;

  assign start_prog  = cmd_done && !cmd_is_erase &&
                       (state == ST_IDLE || (state == ST_ERASE && erase_susp));
  assign start_erase = cmd_done && cmd_is_erase && (state == ST_IDLE) && (|erase_sel);

  assign p_load = start_prog;
  assign p_val  = pprot ? PW'(PPROT_CYC) : PW'(PROG_CYC);
  assign p_run  = (state == ST_PROG) || (state == ST_SPROG);
  assign e_load = start_erase;
  assign e_val  = (live == '0) ? EW'(EPROT_CYC) : EW'(ERASE_CYC);
  assign e_run  = (state == ST_ERASE) && !erase_susp;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pa    <= '0;
      pd7   <= 1'b0;
      emask <= '0;
    end else begin
      if (start_prog) begin
        pa  <= cmd_addr;
        pd7 <= cmd_msb;
      end
      if (start_erase) begin
        emask <= (live == '0) ? erase_sel : live;
      end
      unique case (state)
        ST_IDLE: begin
          if (start_prog)       state <= ST_PROG;
          else if (start_erase) state <= ST_ERASE;
        end
        ST_PROG:  if (p_fin) state <= ST_IDLE;
        ST_ERASE: begin
          if (start_prog) state <= ST_SPROG;
          else if (e_fin) state <= ST_IDLE;
        end
        ST_SPROG: if (p_fin) state <= ST_ERASE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R4: a finished standalone program returns to idle
  a_r4_prog_ends_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROG && p_fin) |=> (state == ST_IDLE));

  // R9: a program inside a suspended erase returns to the erase job
  a_r9_back_to_erase: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SPROG && p_fin) |=> (state == ST_ERASE));

  // R13: a strobe during a running program does not replace its address
  a_r13_cmd_ignored: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROG && cmd_done) |=> $stable(pa));

endmodule

// File: rtl/fpr_addr_match.sv
module fpr_addr_match #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned SECT_W = 4,
  localparam int unsigned NSECT = 2 ** SECT_W
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] pa,
  input  logic [NSECT-1:0]  emask,
  output logic              p_hit,
  output logic              e_hit
);

  logic [SECT_W-1:0] rsec;
  logic [NSECT-1:0]  sect_oh;

  assign rsec = rd_addr[ADDR_W-1 -: SECT_W];

  for (genvar i = 0; i < NSECT; i++) begin : g_sect
    assign sect_oh[i] = (rsec == SECT_W'(i));
  end

  assign p_hit = (rd_addr == pa);
  assign e_hit = |(sect_oh & emask);

endmodule

// File: rtl/fpr_rd_port.sv
module fpr_rd_port
  import fpr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  fpr_state_e        state,
  input  logic              erase_susp,
  input  logic              p_hit,
  input  logic              e_hit,
  input  logic              pd7,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] arr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_status
);

  logic prog_act;
  logic erase_act;
  logic stat_bit;
  logic use_stat;

  assign prog_act  = (state == ST_PROG || state == ST_SPROG) && p_hit;
  assign erase_act = (state == ST_ERASE || state == ST_SPROG) && e_hit;
  assign use_stat  = prog_act || erase_act;

  always_comb begin
    if (prog_act)                                 stat_bit = ~pd7;
    else if (state == ST_SPROG || erase_susp)     stat_bit = 1'b1;
    else                                          stat_bit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      rd_status <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_status <= use_stat;
        rd_data   <= use_stat ? {stat_bit, arr_data[DATA_W-2:0]} : arr_data;
      end
    end
  end

  a_r2_valid_next: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  a_r12_idle_passes: assert property (@(posedge clk) disable iff (rst)
    (rd_en && state == ST_IDLE) |=> (!rd_status && rd_data == $past(arr_data)));

  a_r6_erase_low: assert property (@(posedge clk) disable iff (rst)
    (rd_en && state == ST_ERASE && !erase_susp && e_hit) |=> (rd_status && !rd_data[DATA_W-1]));

  a_r8_susp_high: assert property (@(posedge clk) disable iff (rst)
    (rd_en && state == ST_ERASE && erase_susp && e_hit) |=> (rd_status && rd_data[DATA_W-1]));

endmodule

// File: rtl/flash_poll_responder.sv
module flash_poll_responder
  import fpr_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned SECT_W    = 4,
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned PROG_CYC  = 200,
  parameter int unsigned ERASE_CYC = 20000,
  localparam int unsigned NSECT     = 2 ** SECT_W,
  localparam int unsigned PPROT_CYC = at_least_one(CLK_HZ / 1_000_000),
  localparam int unsigned EPROT_CYC = at_least_one(CLK_HZ / 10_000),
  localparam int unsigned PMAX      = max2(at_least_one(PROG_CYC), PPROT_CYC),
  localparam int unsigned EMAX      = max2(at_least_one(ERASE_CYC), EPROT_CYC),
  localparam int unsigned PW        = $clog2(PMAX + 1),
  localparam int unsigned EW        = $clog2(EMAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_done,
  input  logic              cmd_is_erase,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_msb,
  input  logic [NSECT-1:0]  erase_sel,
  input  logic [NSECT-1:0]  prot_map,
  input  logic              erase_susp,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_status
);

  fpr_state_e        state;
  logic              p_load, p_run, p_fin;
  logic              e_load, e_run, e_fin;
  logic [PW-1:0]     p_val;
  logic [EW-1:0]     e_val;
  logic [ADDR_W-1:0] pa;
  logic              pd7;
  logic [NSECT-1:0]  emask;
  logic              p_hit, e_hit;

  fpr_ctrl #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PW(PW), .EW(EW),
    .PROG_CYC(at_least_one(PROG_CYC)), .ERASE_CYC(at_least_one(ERASE_CYC)),
    .PPROT_CYC(PPROT_CYC), .EPROT_CYC(EPROT_CYC)
  ) ctrl_i (
    .clk(clk), .rst(rst), .cmd_done(cmd_done), .cmd_is_erase(cmd_is_erase),
    .cmd_addr(cmd_addr), .cmd_msb(cmd_msb), .erase_sel(erase_sel),
    .prot_map(prot_map), .erase_susp(erase_susp), .p_fin(p_fin), .e_fin(e_fin),
    .state(state), .p_load(p_load), .p_val(p_val), .p_run(p_run),
    .e_load(e_load), .e_val(e_val), .e_run(e_run), .pa(pa), .pd7(pd7), .emask(emask)
  );

  fpr_timer #(.MAXV(PMAX)) prog_tmr_i (
    .clk(clk), .rst(rst), .load(p_load), .load_val(p_val), .run(p_run), .fin(p_fin)
  );

  fpr_timer #(.MAXV(EMAX)) erase_tmr_i (
    .clk(clk), .rst(rst), .load(e_load), .load_val(e_val), .run(e_run), .fin(e_fin)
  );

  fpr_addr_match #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) match_i (
    .rd_addr(rd_addr), .pa(pa), .emask(emask), .p_hit(p_hit), .e_hit(e_hit)
  );

  fpr_rd_port #(.DATA_W(DATA_W)) port_i (
    .clk(clk), .rst(rst), .state(state), .erase_susp(erase_susp),
    .p_hit(p_hit), .e_hit(e_hit), .pd7(pd7), .rd_en(rd_en), .arr_data(arr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_status(rd_status)
  );

  // R1: status never appears on a read sampled while idle
  a_r1_idle_no_status: assert property (@(posedge clk) disable iff (rst)
    (rd_en && state == ST_IDLE) |=> !rd_status);

endmodule

// File: tb/flash_poll_responder_tb_top.sv
module flash_poll_responder_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_done = 1'b0;
  logic       cmd_is_erase = 1'b0;
  logic [7:0] cmd_addr = '0;
  logic       cmd_msb = 1'b0;
  logic [3:0] erase_sel = '0;
  logic [3:0] prot_map = '0;
  logic       erase_susp = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] arr_data;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rd_status;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // stub array contents
  assign arr_data = rd_addr ^ 8'h5A;

  flash_poll_responder #(
    .DATA_W(8), .ADDR_W(8), .SECT_W(2), .CLK_HZ(10_000_000),
    .PROG_CYC(6), .ERASE_CYC(40)
  ) dut_i (
    .clk(clk), .rst(rst), .cmd_done(cmd_done), .cmd_is_erase(cmd_is_erase),
    .cmd_addr(cmd_addr), .cmd_msb(cmd_msb), .erase_sel(erase_sel), .prot_map(prot_map),
    .erase_susp(erase_susp), .rd_en(rd_en), .rd_addr(rd_addr), .arr_data(arr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_status(rd_status)
  );

  // {erase, addr, data, sel, prot, read addr, exp status, exp top bit}
  localparam logic [34:0] VEC [10] = '{
    {1'b0, 8'h12, 8'hA5, 4'h0, 4'h0, 8'h12, 1'b1, 1'b0},  // R3
    {1'b0, 8'h12, 8'h35, 4'h0, 4'h0, 8'h12, 1'b1, 1'b1},  // R3
    {1'b0, 8'h12, 8'hA5, 4'h0, 4'h0, 8'h13, 1'b0, 1'b0},  // R12
    {1'b0, 8'h45, 8'h80, 4'h0, 4'h2, 8'h45, 1'b1, 1'b0},  // R5
    {1'b1, 8'h00, 8'h00, 4'h1, 4'h0, 8'h10, 1'b1, 1'b0},  // R6
    {1'b1, 8'h00, 8'h00, 4'h1, 4'h0, 8'h50, 1'b0, 1'b0},  // R12
    {1'b1, 8'h00, 8'h00, 4'h6, 4'h4, 8'h70, 1'b1, 1'b0},  // R11
    {1'b1, 8'h00, 8'h00, 4'h6, 4'h4, 8'h90, 1'b0, 1'b0},  // R11
    {1'b1, 8'h00, 8'h00, 4'h4, 4'h4, 8'h81, 1'b1, 1'b0},  // R10
    {1'b1, 8'h00, 8'h00, 4'h0, 4'h0, 8'h00, 1'b0, 1'b0}   // R13
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cmd_done = 1'b0;
    erase_susp = 1'b0;
    rd_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // issues a command; returns at the falling edge after its capture edge
  task automatic cmd(input logic er, input logic [7:0] a, input logic msb,
                     input logic [3:0] sel, input logic [3:0] prot);
    cmd_done = 1'b1;
    cmd_is_erase = er;
    cmd_addr = a;
    cmd_msb = msb;
    erase_sel = sel;
    prot_map = prot;
    @(posedge clk);
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  // one read, sampled at the next edge, checked at the falling edge after
  task automatic rd(input string req, input logic [7:0] a, input logic st, input logic b7);
    logic [7:0] arr;
    logic [7:0] exp_d;
    arr = a ^ 8'h5A;
    exp_d = st ? {b7, arr[6:0]} : arr;
    rd_en = 1'b1;
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, {22'd0, rd_valid, rd_status, rd_data}, {22'd0, 1'b1, st, exp_d});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // table walk
    for (int v = 0; v < 10; v++) begin
      do_reset();
      cmd(VEC[v][34], VEC[v][33:26], VEC[v][25], VEC[v][17:14], VEC[v][13:10]);
      rd($sformatf("vector %0d (R3 R5 R6 R10 R11 R12 R13)", v),
         VEC[v][9:2], VEC[v][1], VEC[v][0]);
    end

    // R1 and R2: reset state and read latency
    do_reset();
    chk("R2 valid low without read", {31'd0, rd_valid}, 32'd0);
    rd("R1 reset reads array", 8'h33, 1'b0, 1'b0);
    wait_cyc(1);
    chk("R2 valid drops", {31'd0, rd_valid}, 32'd0);

    // R3/R4: program end boundary (6 edges)
    do_reset();
    cmd(1'b0, 8'h20, 1'b1, 4'h0, 4'h0);
    wait_cyc(5);
    rd("R3 last status edge", 8'h20, 1'b1, 1'b0);
    rd("R4 array after program", 8'h20, 1'b0, 1'b0);

    // R5: protected program lasts 10 edges
    do_reset();
    cmd(1'b0, 8'h05, 1'b0, 4'h0, 4'h1);
    wait_cyc(9);
    rd("R5 last status edge", 8'h05, 1'b1, 1'b1);
    rd("R5 array after timeout", 8'h05, 1'b0, 1'b0);

    // R7: erase end boundary (40 edges)
    do_reset();
    cmd(1'b1, 8'h00, 1'b0, 4'h2, 4'h0);
    wait_cyc(39);
    rd("R7 last erase status", 8'h41, 1'b1, 1'b0);
    rd("R7 array after erase", 8'h41, 1'b0, 1'b0);

    // R8: 10 suspended edges stretch the erase to edge 50
    do_reset();
    cmd(1'b1, 8'h00, 1'b0, 4'h1, 4'h0);
    erase_susp = 1'b1;
    rd("R8 suspended reads one", 8'h02, 1'b1, 1'b1);
    wait_cyc(9);
    erase_susp = 1'b0;
    wait_cyc(39);
    rd("R8 resumed erase still busy", 8'h02, 1'b1, 1'b0);
    rd("R8 erase done after stretch", 8'h02, 1'b0, 1'b0);

    // R9: program during suspended erase
    do_reset();
    cmd(1'b1, 8'h00, 1'b0, 4'h1, 4'h0);
    erase_susp = 1'b1;
    wait_cyc(1);
    cmd(1'b0, 8'h90, 1'b0, 4'h0, 4'h0);
    rd("R9 nested program complement", 8'h90, 1'b1, 1'b1);
    rd("R9 erase sector reads one", 8'h04, 1'b1, 1'b1);
    wait_cyc(4);
    rd("R9 nested program done", 8'h90, 1'b0, 1'b0);
    rd("R9 erase still pending", 8'h04, 1'b1, 1'b1);

    // R10: all-protected erase lasts 1000 edges
    do_reset();
    cmd(1'b1, 8'h00, 1'b0, 4'h8, 4'h8);
    wait_cyc(999);
    rd("R10 last status edge", 8'hC3, 1'b1, 1'b0);
    rd("R10 array after timeout", 8'hC3, 1'b0, 1'b0);

    // R12: misses during an erase leave its end unchanged
    do_reset();
    cmd(1'b1, 8'h00, 1'b0, 4'h1, 4'h0);
    for (int i = 0; i < 39; i++) begin
      rd_en = 1'b1;
      rd_addr = 8'hC0;
      @(posedge clk);
      @(negedge clk);
    end
    rd_en = 1'b0;
    chk("R12 miss returns array", {24'd0, rd_data}, {24'd0, 8'hC0 ^ 8'h5A});
    rd("R12 erase still at last edge", 8'h01, 1'b1, 1'b0);
    rd("R12 erase ends on time", 8'h01, 1'b0, 1'b0);

    // R13: erase strobe during a program is ignored
    do_reset();
    cmd(1'b0, 8'h20, 1'b0, 4'h0, 4'h0);
    wait_cyc(1);
    cmd(1'b1, 8'h00, 1'b0, 4'h1, 4'h0);
    rd("R13 program unaffected", 8'h20, 1'b1, 1'b1);
    rd("R13 no erase started", 8'h01, 1'b0, 1'b0);
    wait_cyc(1);
    rd("R13 program last edge", 8'h20, 1'b1, 1'b1);
    rd("R13 program ended on time", 8'h20, 1'b0, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule